// File: doc/BRIEF.md
# Serial Configuration Register Write Port

This block sits behind a three-wire serial link made up of a serial clock, a serial data line and an active-low select. It collects 32-bit write frames and commits their payloads into a bank of eight write-only 16-bit configuration registers. The register contents leave the block as one flat parallel bus, so the logic downstream can use the settings directly. Nothing can be read back over the link.

A frame holds a 12-bit sync header, a 4-bit address and a 16-bit value, and it arrives most significant bit first. The block checks the header and decodes the address. It then writes the value on the same clock edge that captures the final bit. It also issues a one-cycle update strobe with the register index, so that consumers can react to the new value. Frames may follow each other with no gap while select stays low. Two sticky flags report problems. One is set by a well-formed frame aimed at an unmapped address. The other is set by a write that completes while an external calibration is in progress.

The whole block is clocked by the serial clock and has a synchronous active-low reset.

Top module: `sfr_write_port`

## Requirements
- R1: After reset, register 0 holds 16'h2000 and registers 2 and 4 hold 16'h8000. All other registers hold 16'h0000, and `wr_stb`, `addr_err` and `cal_warn` are all 0.
- R2: While `sel_n` is low, one bit of `sdi` is taken on each rising edge of `clk`, most significant bit first. Bits 31:20 of a frame are the header, bits 19:16 are the address and bits 15:0 are the value.
- R3: A write takes effect on the edge that captures bit 0, the 32nd bit. On that same edge `wr_stb` rises for exactly one cycle, and `wr_idx` carries the written register index.
- R4: A frame whose header differs from 12'h001 leaves all registers unchanged. It raises neither `wr_stb` nor `addr_err`.
- R5: Raising `sel_n` before the 32nd bit discards the partial frame. The next frame starts again from its first bit.
- R6: While `sel_n` stays low, a new frame begins on the 33rd clock, and back-to-back frames are each decoded correctly.
- R7: Addresses 8 to 15 select registers 0 to 7 (index = address - 8). A valid-header frame aimed at addresses 0 to 7 writes nothing and raises no strobe. It sets `addr_err`, which stays set until reset.
- R8: If `cal_busy` is high when a mapped write completes, the write still takes effect. `cal_warn` becomes 1 and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; data is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low select; high aborts any partial frame |
| sdi | input | 1 | Serial data, most significant bit first |
| cal_busy | input | 1 | High while an external calibration runs |
| cfg_flat | output | 128 | Register i occupies bits [16*i+15:16*i] |
| wr_stb | output | 1 | One-cycle pulse after each committed write |
| wr_idx | output | 3 | Index of the register just written |
| addr_err | output | 1 | Sticky: valid frame to an unmapped address |
| cal_warn | output | 1 | Sticky: write completed during calibration |

## Verification
A bit counter that drifts shows up at the ports within one frame. Either a header check fails, so an expected write is missing from `cfg_flat`, or the strobe appears on the wrong clock, and the bench detects this at the negative edge after the 32nd bit. A wrong decode of the index or data shows up as a mismatched register on that same sample. A flag that loses its sticky state shows up at the next frame boundary. The back-to-back table walk exposes a counter that fails to wrap, because every later frame in the table is then misaligned.

// File: rtl/sfr_pkg.sv
// Shared constants, the decoded-frame type and the reset defaults for the
// serial configuration write port. Assumes an 8-register bank whose mapped
// addresses form one contiguous run starting at MAP_BASE.
package sfr_pkg;
    localparam int FRAME_BITS = 32;
    localparam int HDR_BITS   = 12;
    localparam int ADDR_BITS  = 4;
    localparam int DATA_BITS  = 16;
    localparam int NUM_REGS   = 8;
    localparam int IDX_BITS   = $clog2(NUM_REGS);
    localparam int CNT_BITS   = $clog2(FRAME_BITS);

    localparam logic [HDR_BITS-1:0]  SYNC_WORD = 12'h001;
    localparam logic [ADDR_BITS-1:0] MAP_BASE  = 4'h8;

    typedef struct packed {
        logic                 hdr_ok;
        logic                 mapped;
        logic [IDX_BITS-1:0]  idx;
        logic [DATA_BITS-1:0] data;
    } frame_dec_t;

    // Power-on value of each register: double-rate clocking, zero phase,
    // normal swing, short calibration delay, mid-scale range on both
    // channels, no offset trim, dual-edge sampling off.
    function automatic logic [DATA_BITS-1:0] reg_default(input int idx);
        case (idx)
            0:       reg_default = 16'h2000;
            2, 4:    reg_default = 16'h8000;
            default: reg_default = 16'h0000;
        endcase
    endfunction
endpackage

// File: rtl/sfr_shift_rx.sv
// Serial frame receiver. It shifts sdi in on each rising clk edge while
// sel_n is low, and it flags the cycle in which the last bit of a frame is
// present. Assumes that clk is the serial clock itself. The bit counter wraps
// so frames can follow back to back; sel_n high clears it.
module sfr_shift_rx #(
    parameter int W  = sfr_pkg::FRAME_BITS,
    parameter int CW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_n,
    input  logic         sdi,
    output logic         frame_done,
    output logic [W-1:0] frame_word
);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] bit_cnt;
    logic [W-2:0]  shreg;

    // Count received bits and shift them in; select high aborts the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (sel_n) begin
            bit_cnt <= '0;
        end else begin
            shreg   <= {shreg[W-3:0], sdi};
            bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        end
    end

    // The final bit is still on sdi during the completing cycle.
    always_comb begin
        frame_done = !sel_n && (bit_cnt == LAST);
        frame_word = {shreg, sdi};
    end
endmodule

// File: rtl/sfr_frame_dec.sv
// Frame decoder. It splits a complete frame into header, address and value,
// checks the header against the sync word, and maps the address onto a
// register index. Purely combinational.
module sfr_frame_dec
    import sfr_pkg::*;
(
    input  logic [FRAME_BITS-1:0] word,
    output frame_dec_t            dec
);
    logic [HDR_BITS-1:0]  hdr;
    logic [ADDR_BITS-1:0] addr;
    logic [ADDR_BITS:0]   offs;

    // Slice the fields and locate the address inside the mapped window.
    always_comb begin
        hdr        = word[FRAME_BITS-1 -: HDR_BITS];
        addr       = word[DATA_BITS +: ADDR_BITS];
        offs       = {1'b0, addr} - {1'b0, MAP_BASE};
        dec.hdr_ok = (hdr == SYNC_WORD);
        dec.mapped = !offs[ADDR_BITS] && (offs < (ADDR_BITS+1)'(NUM_REGS));
        dec.idx    = offs[IDX_BITS-1:0];
        dec.data   = word[DATA_BITS-1:0];
    end
endmodule

// File: rtl/sfr_reg_bank.sv
// Bank of write-only configuration registers. Each register loads its reset
// default on reset and takes wr_data when wr_en is high and wr_sel selects it.
// Outputs are packed flat, register i at bits [i*DW +: DW].
module sfr_reg_bank #(
    parameter int N  = sfr_pkg::NUM_REGS,
    parameter int DW = sfr_pkg::DATA_BITS,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [N*DW-1:0] q_flat
);
    for (genvar g = 0; g < N; g++) begin : g_reg
        logic [DW-1:0] q;

        // Hold, reload the default, or capture a write aimed at this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= DW'(sfr_pkg::reg_default(g));
            else if (wr_en && (wr_sel == IW'(g)))
                q <= wr_data;
        end

        assign q_flat[g*DW +: DW] = q;
    end
endmodule

// File: rtl/sfr_write_port.sv
// Top of the serial configuration write port. It chains the receiver,
// decoder and register bank, and it registers the update strobe and the two
// sticky flags. Assumes that all inputs are synchronous to clk (the serial
// clock).
module sfr_write_port
    import sfr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sel_n,
    input  logic                          sdi,
    input  logic                          cal_busy,
    output logic [NUM_REGS*DATA_BITS-1:0] cfg_flat,
    output logic                          wr_stb,
    output logic [IDX_BITS-1:0]           wr_idx,
    output logic                          addr_err,
    output logic                          cal_warn
);
    logic                  frame_done;
    logic [FRAME_BITS-1:0] frame_word;
    frame_dec_t            dec;
    logic                  commit;
    logic                  stray;

    sfr_shift_rx #(.W(FRAME_BITS)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n      (sel_n),
        .sdi        (sdi),
        .frame_done (frame_done),
        .frame_word (frame_word)
    );

    sfr_frame_dec u_dec (
        .word (frame_word),
        .dec  (dec)
    );

    // Classify a completed frame as a write, a stray address or a drop.
    always_comb begin
        commit = frame_done && dec.hdr_ok && dec.mapped;
        stray  = frame_done && dec.hdr_ok && !dec.mapped;
    end

    sfr_reg_bank #(.N(NUM_REGS), .DW(DATA_BITS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_sel  (dec.idx),
        .wr_data (dec.data),
        .q_flat  (cfg_flat)
    );

    // Strobe and index move on the same edge as the register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb <= 1'b0;
            wr_idx <= '0;
        end else begin
            wr_stb <= commit;
            if (commit)
                wr_idx <= dec.idx;
        end
    end

    // Sticky flags; only reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_err <= 1'b0;
            cal_warn <= 1'b0;
        end else begin
            if (stray)
                addr_err <= 1'b1;
            if (commit && cal_busy)
                cal_warn <= 1'b1;
        end
    end
endmodule

// File: rtl/sfr_write_port_chk.sv
// Property checker for sfr_write_port, attached through bind.
module sfr_write_port_chk #(
    parameter int FW = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel_n,
    input logic          cal_busy,
    input logic [FW-1:0] cfg_flat,
    input logic          wr_stb,
    input logic          addr_err,
    input logic          cal_warn
);
    logic past_ok;

    // Marks the cycles in which $past refers to a cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_stb_needs_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && wr_stb) |-> $past(!sel_n));

    p_hold_without_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !wr_stb) |-> $stable(cfg_flat));

    p_stb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(addr_err)) |-> addr_err);

    p_warn_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cal_warn)) |-> cal_warn);

    p_warn_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(cal_warn)) |-> ($past(cal_busy) && wr_stb));
endmodule

bind sfr_write_port sfr_write_port_chk #(
    .FW(sfr_pkg::NUM_REGS * sfr_pkg::DATA_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .cal_busy (cal_busy),
    .cfg_flat (cfg_flat),
    .wr_stb   (wr_stb),
    .addr_err (addr_err),
    .cal_warn (cal_warn)
);

// File: tb/sfr_write_port_tb.sv
module sfr_write_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    // {cal_busy, frame}: header 31:20, address 19:16, value 15:0
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 32'h0018_1111},   // reg0 <- 1111
        {1'b0, 32'h001F_A5A5},   // reg7 <- A5A5
        {1'b0, 32'h0013_FFFF},   // unmapped -> addr_err
        {1'b0, 32'h0039_2222},   // bad header -> dropped
        {1'b1, 32'h001C_5A5A},   // reg4 during calibration -> cal_warn
        {1'b0, 32'h0018_0000}    // reg0 <- 0000
    };

    logic clk = 1'b0;
    logic rst_n, sel_n, sdi, cal_busy;
    logic [127:0] cfg_flat;
    logic wr_stb, addr_err, cal_warn;
    logic [2:0] wr_idx;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_reg [8];
    logic exp_err, exp_warn;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfr_write_port u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sdi(sdi),
        .cal_busy(cal_busy), .cfg_flat(cfg_flat), .wr_stb(wr_stb),
        .wr_idx(wr_idx), .addr_err(addr_err), .cal_warn(cal_warn)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] exp_flat();
        logic [127:0] f;
        for (int i = 0; i < 8; i++) f[i*16 +: 16] = exp_reg[i];
        return f;
    endfunction

    task automatic load_defaults();
        for (int i = 0; i < 8; i++) exp_reg[i] = 16'h0000;
        exp_reg[0] = 16'h2000; exp_reg[2] = 16'h8000; exp_reg[4] = 16'h8000;
        exp_err = 1'b0; exp_warn = 1'b0;
    endtask

    // Drive bits hi..lo of w, one per negedge; returns at the negedge after
    // the last bit has been captured.
    task automatic send_bits(input logic [31:0] w, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            sel_n = 1'b0;
            sdi   = w[i];
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sel_n = 1'b1; sdi = 1'b0; cal_busy = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        load_defaults();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [3:0]  a;
        logic        ok, stb_e;
        do_reset();
        chk("R1", "defaults", cfg_flat, exp_flat());
        chk("R1", "flags", {wr_stb, addr_err, cal_warn}, 3'b000);

        // R2 R6: whole table sent back to back with sel_n held low
        for (int v = 0; v < NV; v++) begin
            w        = VEC[v][31:0];
            cal_busy = VEC[v][32];
            send_bits(w, 31, 0);
            a     = w[19:16];
            ok    = (w[31:20] == 12'h001);
            stb_e = ok && a[3];
            if (stb_e) exp_reg[a[2:0]] = w[15:0];
            if (ok && !a[3]) exp_err = 1'b1;
            if (stb_e && VEC[v][32]) exp_warn = 1'b1;
            chk("R3", "wr_stb", wr_stb, stb_e);
            if (stb_e) chk("R3", "wr_idx", wr_idx, a[2:0]);
            chk(ok ? "R6" : "R4", "registers", cfg_flat, exp_flat());
            chk("R7", "addr_err", addr_err, exp_err);
            chk("R8", "cal_warn", cal_warn, exp_warn);
        end
        cal_busy = 1'b0;
        sel_n = 1'b1;
        @(negedge clk);
        chk("R3", "strobe one cycle", wr_stb, 1'b0);

        // R5: abort after 20 bits, then a complete frame
        send_bits(32'h0019_3333, 31, 12);
        sel_n = 1'b1;
        @(negedge clk);
        chk("R5", "no strobe on abort", wr_stb, 1'b0);
        send_bits(32'h001A_7777, 31, 0);
        exp_reg[2] = 16'h7777;
        chk("R5", "reg1 untouched, reg2 written", cfg_flat, exp_flat());
        chk("R5", "wr_idx", wr_idx, 3'd2);

        // R7: addresses 0 and 7 are unmapped, 15 maps to index 7
        send_bits(32'h0017_1234, 31, 0);
        chk("R7", "no strobe unmapped", wr_stb, 1'b0);
        send_bits(32'h001F_0F0F, 31, 0);
        exp_reg[7] = 16'h0F0F;
        chk("R7", "top address", cfg_flat, exp_flat());
        chk("R7", "idx 7", wr_idx, 3'd7);

        // R4: header off by one bit near the end of the header
        send_bits(32'h0009_BEEF, 31, 0);
        chk("R4", "bad header regs", cfg_flat, exp_flat());
        chk("R4", "bad header strobe", wr_stb, 1'b0);
        sel_n = 1'b1;
        @(negedge clk);

        // R1 R8: reset clears sticky flags and restores defaults
        do_reset();
        chk("R1", "defaults after reset", cfg_flat, exp_flat());
        chk("R8", "flags cleared by reset", {addr_err, cal_warn}, 2'b00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule